// File: doc/BRIEF.md
# Debounced 4x4 Matrix Keypad Scanner

This block scans a matrix of push-button keys wired as four row lines and four column lines. It enables one row line at a time. An enabled row line is driven low. Every other row line is released to high impedance, so the pad acts as open-drain and no two rows ever fight. The column lines have external pull-ups. A column that reads low while a row is enabled means the key at that crossing is pressed. The columns pass through a two-flop resynchroniser. They are sampled once per row step, in the last cycle before the row advances, so the lines have a full step to settle.

The length of a row step comes from a maximal-length LFSR. The LFSR counts from a seed to a terminal state that is computed at elaboration, then reloads the seed. The step length `TICK_CLKS` is chosen so that the required number of stable scans adds up to the wanted debounce time. That time divided by (rows × required scans) gives the clocks per step: 500 at 1 MHz for 8 ms, or 25000 at 50 MHz, which needs a 15-bit LFSR.

Each full scan is classified as idle, one key, or several keys. A key is accepted only after two things have happened in order. First, one idle scan has armed the acceptor. Second, the same single key has been seen on `SCANS_REQ` consecutive scans. Acceptance raises a one-cycle strobe with the key code. The acceptor then disarms until the keypad is idle again.

Top module: `keypad_scanner`

## Requirements
- R1: `row_en` has at most one bit set. Outside reset, the rows are enabled in the order 0, 1, 2, 3, then back to 0, and exactly one row is enabled at any time. A set bit means that row line is driven low. A clear bit means the line is released.
- R2: Every row stays enabled for exactly `TICK_CLKS` clock cycles.
- R3: A low column `c`, seen while row `r` is enabled, is a press of key `r*4+c`. The reported `key_code` is `{r[1:0], c[1:0]}`.
- R4: No key is accepted until one complete scan has shown no key pressed, and this also applies after reset. A key held from reset on is never reported.
- R5: Once armed, the same single key seen on 4 consecutive scans raises `key_valid` for one cycle, together with its code. The strobe appears in the first cycle that row 0 is enabled after the fourth scan.
- R6: If a scan shows a different single key from the previous scan, the count restarts at 1 with the new key.
- R7: A scan with two or more keys pressed, whether in one row or in different rows, clears the count, and no key is reported for that scan.
- R8: After a report, no further key is accepted until another idle scan. A key held on does not repeat.
- R9: `key_valid` is high for a single cycle. `key_code` changes only together with `key_valid` and holds its value otherwise.
- R10: While the synchronous active-low reset is asserted, all rows are released, `key_valid` is low and `key_code` is 0. The arming and count state is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| col_n | input | COLS | Column lines, pulled up; low means pressed on the enabled row |
| row_en | output | ROWS | Row output-enable; 1 drives that row low, 0 releases it |
| key_valid | output | 1 | One-cycle strobe for an accepted key |
| key_code | output | clog2(ROWS)+clog2(COLS) | Code of the last accepted key, {row, col} |

## Verification
Some behaviour is checked by the bound checker on every cycle. It checks that at most one row is enabled, that the rows step in rotation, and that each row is held for the LFSR step length. It also checks that the strobe lasts one cycle, that it arrives only at the start of row 0, and that the code holds between strobes. The acceptance rules can only be shown by the bench's keypad scenarios, checked scan by scan against a reference model. These rules are the idle arming after reset and after each report, the four-scan count, its restart on a changed key, and its clearing on multi-key scans in one row and across rows.

// File: rtl/kps_pkg.sv
// Shared types and elaboration-time helpers for the keypad scanner.
// Assumes LFSR widths from 3 to 16; the tap masks are maximal-length.
package kps_pkg;

    // Outcome of one complete scan of the matrix.
    typedef enum logic [1:0] {
        SCAN_IDLE = 2'd0,
        SCAN_ONE  = 2'd1,
        SCAN_MANY = 2'd2
    } scan_class_t;

    // Feedback tap mask (bit i = tap at stage i+1) for a Fibonacci LFSR.
    function automatic logic [31:0] lfsr_taps(input int w);
        case (w)
            3:       return 32'h0000_0006;
            4:       return 32'h0000_000C;
            5:       return 32'h0000_0014;
            6:       return 32'h0000_0030;
            7:       return 32'h0000_0060;
            8:       return 32'h0000_00B8;
            9:       return 32'h0000_0110;
            10:      return 32'h0000_0240;
            11:      return 32'h0000_0500;
            12:      return 32'h0000_0829;
            13:      return 32'h0000_100D;
            14:      return 32'h0000_2015;
            15:      return 32'h0000_6000;
            16:      return 32'h0000_D008;
            default: return 32'h0000_0003 << (w - 2);
        endcase
    endfunction

    // One shift of a w-bit LFSR held in the low bits of a 32-bit word.
    function automatic logic [31:0] lfsr_step(input logic [31:0] s, input int w);
        logic        fb;
        logic [31:0] mask;
        fb   = ^(s & lfsr_taps(w));
        mask = (32'h1 << w) - 32'h1;
        return ((s << 1) | {31'd0, fb}) & mask;
    endfunction

    // State reached after a number of shifts from a seed (elaboration only).
    function automatic logic [31:0] lfsr_after(input logic [31:0] seed, input int w,
                                               input int steps);
        logic [31:0] s;
        s = seed;
        for (int i = 0; i < steps; i++) begin
            s = lfsr_step(s, w);
        end
        return s;
    endfunction

endpackage

// File: rtl/kps_tick_gen.sv
// Row-step timer. An LFSR runs from a fixed seed to a terminal state
// computed at elaboration, pulses tick in that cycle and reloads the seed,
// giving one tick every TICK_CLKS enabled cycles. Assumes TICK_CLKS is below
// the LFSR period (2**LFSR_W - 1).
module kps_tick_gen
    import kps_pkg::*;
#(
    parameter int TICK_CLKS = 500,
    parameter int LFSR_W    = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam logic [31:0]       SEED32 = 32'd1;
    localparam logic [LFSR_W-1:0] SEED   = LFSR_W'(SEED32);
    localparam logic [LFSR_W-1:0] TERM   = LFSR_W'(lfsr_after(SEED32, LFSR_W, TICK_CLKS - 1));

    logic [LFSR_W-1:0] state;
    logic [31:0]       nxt32;

    // Reject step lengths the synchroniser or the LFSR period cannot honour.
    if (TICK_CLKS < 4 || TICK_CLKS > (1 << LFSR_W) - 1) begin : g_bad_cfg
        $error("kps_tick_gen: TICK_CLKS out of range for LFSR_W");
    end

    // Next LFSR state, widened for the shared step function.
    always_comb begin
        nxt32 = lfsr_step({{(32 - LFSR_W){1'b0}}, state}, LFSR_W);
    end

    assign tick = run && (state == TERM);

    // Advance the LFSR while running, reloading the seed at the terminal state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else if (run) begin
            state <= tick ? SEED : nxt32[LFSR_W-1:0];
        end
    end

endmodule

// File: rtl/kps_col_sync.sv
// Resynchroniser for the asynchronous column lines: a STAGES-deep flop
// chain per bit. Reset loads the idle (pulled-up) level of all ones.
module kps_col_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First capture stage of the raw pins.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= din;
            end
        end else begin : g_next
            // Further stages to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '1;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/kps_row_seq.sv
// Row sequencer. It holds all rows released during reset, then enables one
// row at a time and rotates to the next row on every tick. The started
// flag also gates the step timer, so the first row gets a full step.
module kps_row_seq #(
    parameter int ROWS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tick,
    output logic                    started,
    output logic [$clog2(ROWS)-1:0] row_idx,
    output logic                    last_row,
    output logic [ROWS-1:0]         row_en
);
    localparam int RW = $clog2(ROWS);
    localparam logic [RW-1:0] LAST = RW'(ROWS - 1);

    // Leave the released state one cycle after reset and step rows on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            row_idx <= '0;
        end else begin
            started <= 1'b1;
            if (tick) begin
                row_idx <= (row_idx == LAST) ? '0 : row_idx + RW'(1);
            end
        end
    end

    assign last_row = (row_idx == LAST);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_en[r] = started && (row_idx == RW'(r));
    end

endmodule

// File: rtl/kps_qualifier.sv
// Key acceptor. On each tick it folds the pressed columns of the current row
// into a per-scan summary (key count saturating at "many", plus the code of
// a lone key). At the tick that ends the last row it classifies the scan and
// runs the arm / count / report rule. Assumes pressed is already
// synchronised and active high.
module kps_qualifier
    import kps_pkg::*;
#(
    parameter int ROWS      = 4,
    parameter int COLS      = 4,
    parameter int SCANS_REQ = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 tick,
    input  logic [$clog2(ROWS)-1:0]              row_idx,
    input  logic                                 last_row,
    input  logic [COLS-1:0]                      pressed,
    output logic                                 key_valid,
    output logic [$clog2(ROWS)+$clog2(COLS)-1:0] key_code
);
    localparam int RW = $clog2(ROWS);
    localparam int CW = $clog2(COLS);
    localparam int KW = RW + CW;
    localparam int SW = $clog2(SCANS_REQ + 1);

    logic [1:0]    acc_hits;
    logic [KW-1:0] acc_code;
    logic [1:0]    row_hits;
    logic [1:0]    base_hits;
    logic [KW-1:0] base_code;
    logic [2:0]    hit_sum;
    logic [1:0]    new_hits;
    logic [KW-1:0] new_code;
    logic [CW-1:0] col_pos;
    scan_class_t   scan_class;

    logic          armed;
    logic [SW-1:0] stab_cnt;
    logic [KW-1:0] cand_code;
    logic [SW-1:0] stab_nxt;

    // Number of pressed keys on the sampled row, saturating at two.
    always_comb begin
        if ($countones(pressed) == 0)      row_hits = 2'd0;
        else if ($countones(pressed) == 1) row_hits = 2'd1;
        else                               row_hits = 2'd2;
    end

    // Column index of the lowest pressed column.
    always_comb begin
        col_pos = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (pressed[c]) col_pos = CW'(c);
        end
    end

    // Fold this row into the scan summary; row 0 starts a fresh scan.
    always_comb begin
        base_hits = (row_idx == '0) ? 2'd0 : acc_hits;
        base_code = (row_idx == '0) ? '0   : acc_code;
        hit_sum   = {1'b0, base_hits} + {1'b0, row_hits};
        new_hits  = (hit_sum >= 3'd2) ? 2'd2 : hit_sum[1:0];
        new_code  = (base_hits == 2'd0 && row_hits == 2'd1) ? {row_idx, col_pos} : base_code;
    end

    // Classification of the scan that completes with this tick.
    always_comb begin
        case (new_hits)
            2'd0:    scan_class = SCAN_IDLE;
            2'd1:    scan_class = SCAN_ONE;
            default: scan_class = SCAN_MANY;
        endcase
    end

    // Stability count after a single-key scan.
    always_comb begin
        if (stab_cnt != '0 && cand_code == new_code) stab_nxt = stab_cnt + SW'(1);
        else                                         stab_nxt = SW'(1);
    end

    // Per-scan accumulator registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_hits <= 2'd0;
            acc_code <= '0;
        end else if (tick) begin
            acc_hits <= new_hits;
            acc_code <= new_code;
        end
    end

    // Arm, count and report at the end of every scan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed     <= 1'b0;
            stab_cnt  <= '0;
            cand_code <= '0;
            key_valid <= 1'b0;
            key_code  <= '0;
        end else begin
            key_valid <= 1'b0;
            if (tick && last_row) begin
                case (scan_class)
                    SCAN_IDLE: begin
                        armed    <= 1'b1;
                        stab_cnt <= '0;
                    end
                    SCAN_ONE: begin
                        if (armed) begin
                            cand_code <= new_code;
                            if (stab_nxt == SW'(SCANS_REQ)) begin
                                key_valid <= 1'b1;
                                key_code  <= new_code;
                                armed     <= 1'b0;
                                stab_cnt  <= '0;
                            end else begin
                                stab_cnt <= stab_nxt;
                            end
                        end else begin
                            stab_cnt <= '0;
                        end
                    end
                    default: begin
                        stab_cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/keypad_scanner.sv
// Debounced matrix keypad scanner, top level. It joins the step timer, the
// row sequencer, the column resynchroniser and the key acceptor. Assumes the
// pads drive a row low when its row_en bit is set and release it otherwise,
// and that the columns have external pull-ups.
module keypad_scanner #(
    parameter int ROWS      = 4,
    parameter int COLS      = 4,
    parameter int TICK_CLKS = 500,
    parameter int LFSR_W    = 9,
    parameter int SCANS_REQ = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [COLS-1:0]                      col_n,
    output logic [ROWS-1:0]                      row_en,
    output logic                                 key_valid,
    output logic [$clog2(ROWS)+$clog2(COLS)-1:0] key_code
);
    localparam int RW = $clog2(ROWS);

    logic          started;
    logic          tick;
    logic [RW-1:0] row_idx;
    logic          last_row;
    logic [COLS-1:0] col_sync_n;
    logic [COLS-1:0] pressed;

    kps_tick_gen #(
        .TICK_CLKS (TICK_CLKS),
        .LFSR_W    (LFSR_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (started),
        .tick  (tick)
    );

    kps_row_seq #(
        .ROWS (ROWS)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .started  (started),
        .row_idx  (row_idx),
        .last_row (last_row),
        .row_en   (row_en)
    );

    kps_col_sync #(
        .WIDTH  (COLS),
        .STAGES (2)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (col_n),
        .dout  (col_sync_n)
    );

    assign pressed = ~col_sync_n;

    kps_qualifier #(
        .ROWS      (ROWS),
        .COLS      (COLS),
        .SCANS_REQ (SCANS_REQ)
    ) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .row_idx   (row_idx),
        .last_row  (last_row),
        .pressed   (pressed),
        .key_valid (key_valid),
        .key_code  (key_code)
    );

endmodule

// File: rtl/kps_checker.sv
// Protocol checker for keypad_scanner, attached by bind. It watches only
// the top-level ports. A run counter measures how long each row stays
// enabled, so no deep $past is needed.
module kps_checker #(
    parameter int ROWS      = 4,
    parameter int KW        = 4,
    parameter int TICK_CLKS = 500
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ROWS-1:0] row_en,
    input logic            key_valid,
    input logic [KW-1:0]   key_code
);
    localparam int CNT_W = $clog2(TICK_CLKS + 2) + 1;

    logic [ROWS-1:0]  prev_en;
    logic [CNT_W-1:0] run_len;

    AST_ROW_ONEHOT0: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en)) else $error("more than one row enabled"); // R1

    AST_ROW_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(row_en) != '0 && row_en != $past(row_en))
        |-> row_en == {$past(row_en[ROWS-2:0]), $past(row_en[ROWS-1])})
        else $error("rows out of order"); // R1

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid) else $error("strobe longer than one cycle"); // R9

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> $stable(key_code)) else $error("code moved without strobe"); // R9

    AST_VALID_AT_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> row_en == ROWS'(1)) else $error("strobe away from scan start"); // R5

    // Measure how long each row value is held and check it at every change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_en <= '0;
            run_len <= '0;
        end else begin
            prev_en <= row_en;
            if (row_en != prev_en) begin
                if (prev_en != '0) begin
                    AST_ROW_DWELL: assert (run_len == CNT_W'(TICK_CLKS))
                        else $error("row step length wrong"); // R2
                end
                run_len <= CNT_W'(1);
            end else begin
                run_len <= run_len + CNT_W'(1);
            end
        end
    end

endmodule

bind keypad_scanner kps_checker #(
    .ROWS      (ROWS),
    .KW        ($clog2(ROWS) + $clog2(COLS)),
    .TICK_CLKS (TICK_CLKS)
) u_kps_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .row_en    (row_en),
    .key_valid (key_valid),
    .key_code  (key_code)
);

// File: tb/keypad_scanner_test.sv
// Bench: a keypad model pulls columns low for pressed keys on the enabled
// row. Each key pattern is held for one whole scan, and the bench compares
// each scan's outcome with a reference model of the acceptance rules.
module keypad_scanner_test;
    localparam int TICK = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_n;
    logic [3:0] row_en;
    logic       key_valid;
    logic [3:0] key_code;
    logic [15:0] keys = 16'h0;

    int total = 0;
    int bad   = 0;

    // Reference model state.
    bit       m_armed = 0;
    int       m_stab  = 0;
    int       m_cand  = 0;
    int       m_last  = 0;

    always #2 clk = ~clk;

    keypad_scanner #(
        .ROWS(4), .COLS(4), .TICK_CLKS(TICK), .LFSR_W(4), .SCANS_REQ(4)
    ) uut (
        .clk(clk), .rst_n(rst_n), .col_n(col_n),
        .row_en(row_en), .key_valid(key_valid), .key_code(key_code)
    );

    // Keypad matrix: a pressed key on an enabled row pulls its column low.
    always_comb begin
        col_n = 4'hF;
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                if (row_en[r] && keys[r*4+c]) col_n[c] = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference rule applied to one completed scan.
    task automatic model_scan(input logic [15:0] pat, output bit ev, output int ec);
        int n;
        int k;
        n = $countones(pat);
        ev = 0;
        ec = m_last;
        if (n == 0) begin
            m_armed = 1; m_stab = 0;
        end else if (n > 1) begin
            m_stab = 0;
        end else begin
            k = 0;
            for (int i = 0; i < 16; i++) if (pat[i]) k = i;
            if (!m_armed) m_stab = 0;
            else begin
                if (m_stab != 0 && m_cand == k) m_stab++;
                else m_stab = 1;
                m_cand = k;
                if (m_stab == 4) begin
                    ev = 1; ec = k; m_last = k;
                    m_armed = 0; m_stab = 0;
                end
            end
        end
    endtask

    // Hold one pattern for a whole scan; called at a negedge inside row 0.
    task automatic run_scan(input logic [15:0] pat, input string req);
        bit ev;
        int ec;
        int dwell;
        keys = pat;
        for (int r = 0; r < 4; r++) begin
            chk(row_en == 4'(1 << r), "R1", "row order", int'(row_en), 1 << r);
            dwell = 0;
            while (row_en == 4'(1 << r) && dwell < 4 * TICK) begin
                dwell++;
                @(negedge clk);
            end
            if (r != 0) chk(dwell == TICK, "R2", "row dwell", dwell, TICK);
        end
        model_scan(pat, ev, ec);
        chk(key_valid == ev, req, "strobe", int'(key_valid), int'(ev));
        chk(key_code == 4'(ec), ev ? "R3" : "R9", "code", int'(key_code), ec);
        if (key_valid) begin
            @(negedge clk);
            chk(!key_valid, "R9", "strobe width", int'(key_valid), 0);
        end
    endtask

    task automatic repeat_scan(input logic [15:0] pat, input int n, input string req);
        for (int i = 0; i < n; i++) run_scan(pat, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(row_en == 4'h0, "R10", "rows released", int'(row_en), 0);
        chk(!key_valid, "R10", "strobe in reset", int'(key_valid), 0);
        chk(key_code == 4'h0, "R10", "code in reset", int'(key_code), 0);
        m_armed = 0; m_stab = 0; m_cand = 0; m_last = 0;
        rst_n = 1'b1;
        while (row_en != 4'b0001) @(negedge clk);
    endtask

    function automatic logic [15:0] one(input int k);
        return 16'(1) << k;
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int mode;
        int k;
        int n;
        logic [15:0] p;
        void'($urandom(32'd2024));
        keys = one(5);
        do_reset();
        // R4: key held from reset, never seen idle.
        repeat_scan(one(5), 5, "R4");
        // R5 / R3: arm, then four stable scans.
        run_scan(16'h0, "R4");
        repeat_scan(one(5), 4, "R5");
        // R8: held key does not repeat.
        repeat_scan(one(5), 3, "R8");
        // R6: key change restarts the count.
        run_scan(16'h0, "R8");
        repeat_scan(one(9), 2, "R6");
        repeat_scan(one(10), 4, "R6");
        // R7: two keys in one row, then two keys in different rows.
        run_scan(16'h0, "R7");
        repeat_scan(one(3), 2, "R7");
        run_scan(16'h0003, "R7");
        repeat_scan(one(3), 4, "R7");
        run_scan(16'h0, "R7");
        repeat_scan(one(6), 3, "R7");
        run_scan(16'h4004, "R7");
        repeat_scan(one(6), 4, "R7");
        // R3: corner codes.
        run_scan(16'h0, "R3");
        repeat_scan(one(15), 4, "R3");
        run_scan(16'h0, "R3");
        repeat_scan(one(0), 4, "R3");
        // R10: reset mid-press clears arming.
        run_scan(16'h0, "R10");
        repeat_scan(one(12), 2, "R10");
        keys = one(12);
        do_reset();
        repeat_scan(one(12), 4, "R10");
        // Random mix.
        for (int i = 0; i < 60; i++) begin
            mode = int'($urandom % 4);
            if (mode == 0) begin
                repeat_scan(16'h0, 1 + int'($urandom % 2), "R4");
            end else if (mode == 3) begin
                p = 16'($urandom);
                if ($countones(p) < 2) p = p | 16'h0101;
                run_scan(p, "R7");
            end else begin
                k = int'($urandom % 16);
                n = 1 + int'($urandom % 6);
                repeat_scan(one(k), n, "R5");
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule